// File: doc/BRIEF.md
# Banked Memory Window and Operator Port Decoder for an ISA Expansion Card

This block is the address-decode glue of a custom ISA expansion card. A 64 KiB host memory window is mapped onto a larger on-card bank space. A 5-bit bank register chooses which 64 KiB page of that space the window shows. The lower part of the bank space is a 1 MiB boot ROM. The next part is a 512 KiB flash device. The top eight pages are unpopulated.

A small cluster of I/O ports sits next to the window:
- a write-only port that loads the bank register;
- a port that bit-bangs a three-wire security key (reset, clock and data lines);
- a read-only operator port that carries the coin switches and two service buttons;
- four reserved ports that read as all ones.

Reads are combinational. While the host holds a read strobe, `host_rdata` shows the selected source, and `host_rdata_oe` tells the board-level buffer when to drive the bus. Writes take effect at the rising clock edge that samples the strobe.

There is no valid/ready handshake and no back-pressure. Every access completes within the strobe that carries it. The ROM and flash must return data combinationally from `mem_page_addr`.

Top module: `isa_bank_window`

## Requirements
- R1: After reset the bank register is 0, so a window read selects ROM page 0 and the three key pins are low.
- R2: An I/O write to port 0x22F loads the bank register with data bits 4..0, ignores bits 7..5, and is visible from the next clock edge.
- R3: Memory strobes with host addresses outside 0xD0000..0xDFFFF assert no chip select and do not enable the data output.
- R4: For banks 0..15, a window read asserts `rom_cs` and returns `rom_rdata`. A window write in these banks asserts no chip select.
- R5: For banks 16..23, window reads and writes assert `flash_cs`, `flash_we` is high only for writes, and reads return `flash_rdata`.
- R6: For banks 24..31, a window access asserts no chip select, and reads return 0xFF with the output enabled.
- R7: In every window access `mem_page_addr` equals bank × 65536 + (host address bits 15..0).
- R8: An I/O write to port 0x22D registers data bit 6 onto `key_rst`, bit 4 onto `key_clk` and bit 5 onto `key_dq_out`. The pins hold their values until the next such write.
- R9: An I/O read of port 0x22D returns 0xFF when `key_dq_in` is high and 0xDF when it is low.
- R10: An I/O read of port 0x22C returns a byte with bit 0 = NOT `btn_setup`, bit 1 = NOT `btn_calib`, bits 5..2 = `coin_in[3:0]`, and bits 7..6 = 1.
- R11: I/O reads of ports 0x228..0x22B return 0xFF with the output enabled. Reads of any other undecoded port, including the write-only 0x22F, return 0xFF with the output disabled.
- R12: `host_rdata_oe` is high only while a read strobe addresses the window or ports 0x228..0x22D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 20 | Host address; I/O cycles use bits 15..0 |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| mem_rd | input | 1 | Memory read strobe, active high |
| mem_wr | input | 1 | Memory write strobe, active high |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data; 0xFF when nothing is decoded |
| host_rdata_oe | output | 1 | Enable for the host data bus driver |
| mem_page_addr | output | 21 | Bank-space byte address |
| rom_cs | output | 1 | Boot ROM select (reads only) |
| rom_rdata | input | 8 | Boot ROM read data |
| flash_cs | output | 1 | Flash select |
| flash_we | output | 1 | Flash write enable |
| flash_wdata | output | 8 | Data presented to the flash |
| flash_rdata | input | 8 | Flash read data |
| key_rst | output | 1 | Security-key reset line |
| key_clk | output | 1 | Security-key clock line |
| key_dq_out | output | 1 | Security-key data line, driven value |
| key_dq_in | input | 1 | Security-key data line, sensed value |
| btn_setup | input | 1 | Setup button, 1 = pressed |
| btn_calib | input | 1 | Calibrate button, 1 = pressed |
| coin_in | input | 4 | Coin switches, 1 = active |

## Verification
The bench builds the block with its default parameters: 16 ROM banks, 8 flash banks and a 5-bit bank register. With these values every one of the 32 bank codes can be reached from the bank port. This includes the boundary codes 15/16 between ROM and flash, 23/24 between flash and the empty pages, and 31, the last empty page. Written values with the upper three bits set show that those bits are discarded. Stimulus also covers both edges of the window and the I/O addresses just outside the port cluster.

// File: rtl/isa_card_pkg.sv
package isa_card_pkg;

  // Which on-card device the current bank maps to
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_ROM   = 2'd1,
    TGT_FLASH = 2'd2
  } win_tgt_e;

  // Value seen on an undriven, pulled-up bus
  localparam logic [7:0] BUS_IDLE = 8'hFF;

endpackage

// File: rtl/isa_bank_select.sv
module isa_bank_select
  import isa_card_pkg::*;
#(
  parameter int BANK_W      = 5,
  parameter int ROM_BANKS   = 16,
  parameter int FLASH_BANKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank,
  output win_tgt_e          target
);

  localparam int FLASH_END = ROM_BANKS + FLASH_BANKS;

  always_ff @(posedge clk) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= load_val;
  end

  always_comb begin
    if (int'(bank) < ROM_BANKS)      target = TGT_ROM;
    else if (int'(bank) < FLASH_END) target = TGT_FLASH;
    else                             target = TGT_NONE;
  end

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank == $past(load_val));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));

endmodule

// File: rtl/isa_key_port.sv
module isa_key_port (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic rst_bit,
  input  logic clk_bit,
  input  logic dq_bit,
  output logic key_rst,
  output logic key_clk,
  output logic key_dq_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_rst    <= 1'b0;
      key_clk    <= 1'b0;
      key_dq_out <= 1'b0;
    end else if (wr_hit) begin
      key_rst    <= rst_bit;
      key_clk    <= clk_bit;
      key_dq_out <= dq_bit;
    end
  end

  // R8
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable({key_rst, key_clk, key_dq_out}));

  // R8
  key_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (key_clk == $past(clk_bit)) && (key_dq_out == $past(dq_bit)));

endmodule

// File: rtl/isa_window_decode.sv
module isa_window_decode
  import isa_card_pkg::*;
#(
  parameter int               HOST_AW  = 20,
  parameter int               WIN_W    = 16,
  parameter int               BANK_W   = 5,
  parameter logic [HOST_AW-1:0] WIN_BASE = 20'hD0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HOST_AW-1:0]      host_addr,
  input  logic                    mem_rd,
  input  logic                    mem_wr,
  input  logic [BANK_W-1:0]       bank,
  input  win_tgt_e                target,
  output logic                    win_hit,
  output logic                    rom_cs,
  output logic                    flash_cs,
  output logic                    flash_we,
  output logic [BANK_W+WIN_W-1:0] page_addr
);

  assign win_hit = (host_addr[HOST_AW-1:WIN_W] == WIN_BASE[HOST_AW-1:WIN_W]);

  always_comb begin
    rom_cs   = 1'b0;
    flash_cs = 1'b0;
    flash_we = 1'b0;
    if (win_hit) begin
      unique case (target)
        TGT_ROM:   rom_cs = mem_rd;
        TGT_FLASH: begin
          flash_cs = mem_rd | mem_wr;
          flash_we = mem_wr;
        end
        default: ;
      endcase
    end
  end

  assign page_addr = {bank, host_addr[WIN_W-1:0]};

  // R4 R5
  cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && flash_cs));

  // R5
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_we |-> flash_cs && mem_wr);

  // R4
  rom_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> mem_rd);

endmodule

// File: rtl/isa_bank_window.sv
module isa_bank_window
  import isa_card_pkg::*;
#(
  parameter int          HOST_AW     = 20,
  parameter int          IO_AW       = 16,
  parameter int          WIN_W       = 16,
  parameter int          BANK_W      = 5,
  parameter int          ROM_BANKS   = 16,
  parameter int          FLASH_BANKS = 8,
  parameter logic [19:0] WIN_BASE    = 20'hD0000,
  parameter logic [15:0] IO_BASE     = 16'h0228,
  parameter int          KEY_RST_BIT = 6,
  parameter int          KEY_CLK_BIT = 4,
  parameter int          KEY_DQ_BIT  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HOST_AW-1:0]      host_addr,
  input  logic                    io_rd,
  input  logic                    io_wr,
  input  logic                    mem_rd,
  input  logic                    mem_wr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  output logic                    host_rdata_oe,
  output logic [BANK_W+WIN_W-1:0] mem_page_addr,
  output logic                    rom_cs,
  input  logic [7:0]              rom_rdata,
  output logic                    flash_cs,
  output logic                    flash_we,
  output logic [7:0]              flash_wdata,
  input  logic [7:0]              flash_rdata,
  output logic                    key_rst,
  output logic                    key_clk,
  output logic                    key_dq_out,
  input  logic                    key_dq_in,
  input  logic                    btn_setup,
  input  logic                    btn_calib,
  input  logic [3:0]              coin_in
);

  // Port offsets within the cluster are fixed by the card's software
  localparam logic [IO_AW-1:0] RSV_LO    = IO_BASE[IO_AW-1:0];
  localparam logic [IO_AW-1:0] RSV_HI    = IO_BASE[IO_AW-1:0] + 16'd3;
  localparam logic [IO_AW-1:0] COIN_PORT = IO_BASE[IO_AW-1:0] + 16'd4;
  localparam logic [IO_AW-1:0] KEY_PORT  = IO_BASE[IO_AW-1:0] + 16'd5;
  localparam logic [IO_AW-1:0] BANK_PORT = IO_BASE[IO_AW-1:0] + 16'd7;
  localparam logic [7:0]       KEY_LOW   = BUS_IDLE & ~(8'd1 << KEY_DQ_BIT);

  logic [IO_AW-1:0]  io_a;
  logic              bank_wr, key_wr;
  logic              rsv_hit, coin_hit, key_hit;
  logic [BANK_W-1:0] bank;
  win_tgt_e          target;
  logic              win_hit;
  logic [7:0]        coin_byte;

  assign io_a     = host_addr[IO_AW-1:0];
  assign bank_wr  = io_wr && (io_a == BANK_PORT);
  assign key_wr   = io_wr && (io_a == KEY_PORT);
  assign rsv_hit  = (io_a >= RSV_LO) && (io_a <= RSV_HI);
  assign coin_hit = (io_a == COIN_PORT);
  assign key_hit  = (io_a == KEY_PORT);

  isa_bank_select #(
    .BANK_W      (BANK_W),
    .ROM_BANKS   (ROM_BANKS),
    .FLASH_BANKS (FLASH_BANKS)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (bank_wr),
    .load_val (host_wdata[BANK_W-1:0]),
    .bank     (bank),
    .target   (target)
  );

  isa_key_port u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (key_wr),
    .rst_bit    (host_wdata[KEY_RST_BIT]),
    .clk_bit    (host_wdata[KEY_CLK_BIT]),
    .dq_bit     (host_wdata[KEY_DQ_BIT]),
    .key_rst    (key_rst),
    .key_clk    (key_clk),
    .key_dq_out (key_dq_out)
  );

  isa_window_decode #(
    .HOST_AW  (HOST_AW),
    .WIN_W    (WIN_W),
    .BANK_W   (BANK_W),
    .WIN_BASE (WIN_BASE)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .bank      (bank),
    .target    (target),
    .win_hit   (win_hit),
    .rom_cs    (rom_cs),
    .flash_cs  (flash_cs),
    .flash_we  (flash_we),
    .page_addr (mem_page_addr)
  );

  assign flash_wdata = host_wdata;

  // Service buttons read low when pressed, coins read high
  assign coin_byte = {2'b11, coin_in, ~btn_calib, ~btn_setup};

  always_comb begin
    host_rdata    = BUS_IDLE;
    host_rdata_oe = 1'b0;
    if (mem_rd && win_hit) begin
      host_rdata_oe = 1'b1;
      unique case (target)
        TGT_ROM:   host_rdata = rom_rdata;
        TGT_FLASH: host_rdata = flash_rdata;
        default:   host_rdata = BUS_IDLE;
      endcase
    end else if (io_rd) begin
      if (rsv_hit) begin
        host_rdata_oe = 1'b1;
      end else if (coin_hit) begin
        host_rdata_oe = 1'b1;
        host_rdata    = coin_byte;
      end else if (key_hit) begin
        host_rdata_oe = 1'b1;
        host_rdata    = key_dq_in ? BUS_IDLE : KEY_LOW;
      end
    end
  end

  // R12
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata_oe |-> (io_rd || mem_rd));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata_oe |-> host_rdata == 8'hFF);

  // R9
  key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !mem_rd && key_hit) |-> host_rdata[KEY_DQ_BIT] == key_dq_in);

endmodule

// File: tb/isa_bank_window_test.sv
`timescale 1ns/100ps
module isa_bank_window_test;

  typedef struct packed {
    logic [31:0] tag;
    logic [7:0]  data;
    logic        oe;
    logic        rom;
    logic        flash;
    logic        chk_page;
    logic [20:0] page;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] host_addr = '0;
  logic        io_rd = 0, io_wr = 0, mem_rd = 0, mem_wr = 0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rdata_oe;
  logic [20:0] mem_page_addr;
  logic        rom_cs, flash_cs, flash_we;
  logic [7:0]  rom_rdata, flash_rdata, flash_wdata;
  logic        key_rst, key_clk, key_dq_out;
  logic        key_dq_in = 1'b0;
  logic        btn_setup = 0, btn_calib = 0;
  logic [3:0]  coin_in = '0;

  int   nchk = 0;
  int   nerr = 0;
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [4:0] b, input logic [15:0] o);
    return o[7:0] ^ {3'b000, b} ^ 8'h5A;
  endfunction
  function automatic logic [7:0] flash_byte(input logic [4:0] b, input logic [15:0] o);
    return ~o[7:0] ^ o[15:8] ^ {3'b000, b};
  endfunction

  assign rom_rdata   = rom_byte(mem_page_addr[20:16], mem_page_addr[15:0]);
  assign flash_rdata = flash_byte(mem_page_addr[20:16], mem_page_addr[15:0]);

  isa_bank_window uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
    .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
    .mem_page_addr(mem_page_addr), .rom_cs(rom_cs), .rom_rdata(rom_rdata),
    .flash_cs(flash_cs), .flash_we(flash_we), .flash_wdata(flash_wdata),
    .flash_rdata(flash_rdata), .key_rst(key_rst), .key_clk(key_clk),
    .key_dq_out(key_dq_out), .key_dq_in(key_dq_in), .btn_setup(btn_setup),
    .btn_calib(btn_calib), .coin_in(coin_in)
  );

  task automatic check(input logic [31:0] tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [31:0] tag, input logic [7:0] d, input logic oe,
                              input logic r, input logic f, input logic cp, input logic [20:0] p);
    exp_t e;
    e.tag = tag; e.data = d; e.oe = oe; e.rom = r; e.flash = f; e.chk_page = cp; e.page = p;
    return e;
  endfunction

  // Driver: one-cycle read, expectation queued for the monitor
  task automatic do_read(input bit is_mem, input logic [19:0] a, input exp_t e);
    @(negedge clk);
    host_addr = a;
    if (is_mem) mem_rd = 1'b1; else io_rd = 1'b1;
    q.push_back(e);
    @(negedge clk);
    mem_rd = 1'b0; io_rd = 1'b0;
  endtask

  task automatic do_io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = {4'h0, a}; host_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic win_read(input logic [31:0] tag, input logic [4:0] b, input logic [15:0] o);
    int bi;
    bi = int'(b);
    if (bi < 16)      do_read(1, {4'hD, o}, mk(tag, rom_byte(b, o), 1, 1, 0, 1, {b, o}));
    else if (bi < 24) do_read(1, {4'hD, o}, mk(tag, flash_byte(b, o), 1, 0, 1, 1, {b, o}));
    else              do_read(1, {4'hD, o}, mk(tag, 8'hFF, 1, 0, 0, 1, {b, o}));
  endtask

  // Monitor: pops and compares while a read strobe is held
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (io_rd || mem_rd) begin
        if (q.size() == 0) begin
          check("SB", 32'd0, 32'd1);
        end else begin
          e = q.pop_front();
          check(e.tag, {24'd0, host_rdata}, {24'd0, e.data});
          check(e.tag, {31'd0, host_rdata_oe}, {31'd0, e.oe});
          check(e.tag, {30'd0, rom_cs, flash_cs}, {30'd0, e.rom, e.flash});
          if (e.chk_page) check(e.tag, {11'd0, mem_page_addr}, {11'd0, e.page});
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 R12: reset state and idle bus
    check("R1", {29'd0, key_rst, key_clk, key_dq_out}, 32'd0);
    check("R12", {31'd0, host_rdata_oe}, 32'd0);
    win_read("R1", 5'd0, 16'h0010);

    // R2: upper bits ignored, R7 page address
    do_io_write(16'h022F, 8'hE3);
    win_read("R2", 5'd3, 16'h0ABC);
    win_read("R7", 5'd3, 16'hFFFF);
    do_io_write(16'h022F, 8'h0F);
    win_read("R4", 5'd15, 16'h8001);

    // R3: just outside the window
    do_read(1, 20'hCFFFF, mk("R3", 8'hFF, 0, 0, 0, 0, '0));
    do_read(1, 20'hE0000, mk("R3", 8'hFF, 0, 0, 0, 0, '0));

    // R4: ROM ignores writes
    @(negedge clk); host_addr = 20'hD0042; mem_wr = 1'b1; #1;
    check("R4", {30'd0, rom_cs, flash_cs}, 32'd0);
    @(negedge clk); mem_wr = 1'b0;

    // R5: flash read at both ends, write with enable
    do_io_write(16'h022F, 8'h10);
    win_read("R5", 5'd16, 16'h0005);
    do_io_write(16'h022F, 8'h37);
    win_read("R5", 5'd23, 16'h7F3C);
    @(negedge clk); host_addr = 20'hD1234; host_wdata = 8'hA5; mem_wr = 1'b1; #1;
    check("R5", {29'd0, rom_cs, flash_cs, flash_we}, 32'b011);
    check("R7", {11'd0, mem_page_addr}, {11'd0, 5'd23, 16'h1234});
    check("R5", {24'd0, flash_wdata}, 32'hA5);
    @(negedge clk); mem_wr = 1'b0;

    // R6: empty pages, 0xF8 also shows upper bits dropped
    do_io_write(16'h022F, 8'hF8);
    win_read("R6", 5'd24, 16'h0100);
    do_io_write(16'h022F, 8'h1F);
    win_read("R6", 5'd31, 16'hFFFE);
    @(negedge clk); host_addr = 20'hD0000; mem_wr = 1'b1; #1;
    check("R6", {30'd0, rom_cs, flash_cs}, 32'd0);
    @(negedge clk); mem_wr = 1'b0;

    // R8: key pins, hold across other writes
    do_io_write(16'h022D, 8'h70);
    #1 check("R8", {29'd0, key_rst, key_clk, key_dq_out}, 32'b111);
    do_io_write(16'h022D, 8'h10);
    #1 check("R8", {29'd0, key_rst, key_clk, key_dq_out}, 32'b010);
    do_io_write(16'h022F, 8'h00);
    do_io_write(16'h022C, 8'hFF);
    #1 check("R8", {29'd0, key_rst, key_clk, key_dq_out}, 32'b010);
    do_io_write(16'h022D, 8'h60);
    #1 check("R8", {29'd0, key_rst, key_clk, key_dq_out}, 32'b101);

    // R9: key data readback
    key_dq_in = 1'b1;
    do_read(0, 20'h0022D, mk("R9", 8'hFF, 1, 0, 0, 0, '0));
    key_dq_in = 1'b0;
    do_read(0, 20'h0022D, mk("R9", 8'hDF, 1, 0, 0, 0, '0));

    // R10: coin port patterns
    btn_setup = 1; btn_calib = 0; coin_in = 4'b1010;
    do_read(0, 20'h0022C, mk("R10", 8'b1110_1010, 1, 0, 0, 0, '0));
    btn_setup = 0; btn_calib = 1; coin_in = 4'b0101;
    do_read(0, 20'h0022C, mk("R10", 8'b1101_0101, 1, 0, 0, 0, '0));
    btn_setup = 0; btn_calib = 0; coin_in = 4'b0000;
    do_read(0, 20'h0022C, mk("R10", 8'b1100_0011, 1, 0, 0, 0, '0));

    // R11: reserved and undecoded ports
    for (int i = 0; i < 4; i++)
      do_read(0, 20'h00228 + 20'(i), mk("R11", 8'hFF, 1, 0, 0, 0, '0));
    do_read(0, 20'h0022F, mk("R11", 8'hFF, 0, 0, 0, 0, '0));
    do_read(0, 20'h0022E, mk("R11", 8'hFF, 0, 0, 0, 0, '0));
    do_read(0, 20'h00227, mk("R11", 8'hFF, 0, 0, 0, 0, '0));

    // R12: window address with no strobe
    @(negedge clk); host_addr = 20'hD0000; #1;
    check("R12", {30'd0, host_rdata_oe, rom_cs}, 32'd0);

    repeat (3) @(negedge clk);
    check("SB", q.size(), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule